// File: doc/BRIEF.md
# SD Card Single-Block SPI Read Engine

This block fetches one data block from an SD card that has already been brought up in SPI mode. The host gives it a block index, a flag that says whether the card counts its address in blocks or in bytes, and a limit on how long to wait for data. It then pulses `start`. The engine drives the serial pins for the whole transaction. It lowers chip select and clocks out two idle bytes. It sends the single-block read command with its 32-bit argument and polls for the one-byte R1 reply. After that it waits for the start-data token.

Once the token arrives, every data byte is handed to the host on a one-cycle `rd_valid` strobe, with the byte on `rd_data`. A CCITT CRC16 is accumulated over those bytes and compared with the two check bytes that follow them. The engine then raises `done` for one cycle with a result code. It deasserts chip select and sends one trailing idle byte, after which it releases `busy`. While it is not busy, the serial outputs rest in their idle levels.

Top module: `sdrd_read_engine`

## Requirements
- R1: On `start` while idle, chip select goes low and the engine sends two 0xFF bytes, then six command bytes: 0x51, the 32-bit argument most significant byte first, and a trailer byte of 0xFF. SPI mode 0 is used: SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the rising edge.
- R2: With `blk_addr_mode`=0 (byte-addressed card), the argument is `blk_idx` times BLOCK_BYTES, a power of two, truncated to 32 bits.
- R3: With `blk_addr_mode`=1 (block-addressed card), the argument is `blk_idx` unchanged.
- R4: After the command the engine polls with 0xFF bytes. A reply byte with bit 7 clear is R1. If NCR_MAX polled bytes all have bit 7 set, the read ends with code 5 (no reply).
- R5: A nonzero R1 (for example 0x20, address error) ends the read with code 1. The engine clocks no further byte under chip select and delivers no data.
- R6: After R1 = 0x00, 0xFF bytes are skipped until the token 0xFE. A token after up to `tok_limit`-1 idle bytes is accepted (`tok_limit` must be at least 1).
- R7: If `tok_limit` idle bytes are seen without a token, the read ends with code 3 (timeout) and delivers no data.
- R8: A byte with its top three bits 000 in place of the token ends the read with code 2 and delivers no data.
- R9: After the token, exactly BLOCK_BYTES bytes are delivered in arrival order. Each one is marked by `rd_valid` high for a single cycle.
- R10: The two bytes after the data, high byte first, are compared with the CRC16 of the data (polynomial 0x1021, initial value 0, most significant bit first). A match gives code 0 and a mismatch gives code 4; the data is delivered in both cases.
- R11: Completion is one `done` pulse carrying `err_code`, with chip select already high. Exactly one more byte (8 SCLK periods) of 0xFF follows with chip select high, then `busy` falls.
- R12: `start` while busy is ignored: only one command is sent, and its argument and data belong to the first request.
- R13: While not busy, `spi_cs_n`=1, `spi_sclk`=0 and `spi_mosi`=1. This is also the state during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read when idle |
| blk_idx | input | 32 | Block index to read |
| blk_addr_mode | input | 1 | 1 = card addressed in blocks, 0 = in bytes |
| tok_limit | input | TOKW | Idle bytes tolerated before the token |
| busy | output | 1 | Transaction in progress; engine owns the pins |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 ok, 1 R1 error, 2 data error token, 3 timeout, 4 CRC mismatch, 5 no R1 |
| rd_valid | output | 1 | Data byte strobe |
| rd_data | output | 8 | Data byte |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_mosi | output | 1 | Serial data to card |
| spi_miso | input | 1 | Serial data from card |

## Verification
A behavioural card model decodes the command bytes and replies with a configurable R1, a configurable run of idle bytes and a configurable token. It then supplies a generated data pattern and a CRC that is either correct or corrupted. Byte- and block-addressed reads, including an index whose byte address overflows 32 bits, tell the two argument forms apart. Idle runs one below and exactly at the limit, an error token and a nonzero R1 separate the early exits from the data path. The exits are also separated from each other by code, by the number of bytes delivered and by how many bytes were clocked. A corrupted check byte, and a second `start` during a read, confirm that the CRC compare and the request capture act independently of the data stream.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_CMD   = 3'd2,
        ST_R1    = 3'd3,
        ST_TOKEN = 3'd4,
        ST_DATA  = 3'd5,
        ST_CRC   = 3'd6,
        ST_TRAIL = 3'd7
    } sdrd_state_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_R1      = 3'd1,
        ERR_TOKEN   = 3'd2,
        ERR_TIMEOUT = 3'd3,
        ERR_CRC     = 3'd4,
        ERR_NO_R1   = 3'd5
    } sdrd_err_e;

    localparam logic [7:0] IDLE_BYTE   = 8'hFF;
    localparam logic [7:0] CMD_RD_ONE  = 8'h51;
    localparam logic [7:0] START_TOKEN = 8'hFE;
    localparam logic [15:0] CRC_POLY   = 16'h1021;

    // Bit-serial CCITT update, message bits taken most significant first.
    function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] r;
        logic        fb;
        r = cur;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ din[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/sdrd_spi_byte.sv
module sdrd_spi_byte #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic [2:0]       bitn;
        logic [DIV_W-1:0] div;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic             done;
    } sh_s;

    sh_s sh_q, sh_d;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.active) begin
            if (go) begin
                sh_d.active = 1'b1;
                sh_d.tx     = tx_byte;
                sh_d.bitn   = '0;
                sh_d.div    = '0;
                sh_d.sclk   = 1'b0;
            end
        end else if (sh_q.div == DIV_W'(HALF_DIV - 1)) begin
            sh_d.div = '0;
            if (!sh_q.sclk) begin
                sh_d.sclk = 1'b1;
                sh_d.rx   = {sh_q.rx[6:0], miso};
            end else begin
                sh_d.sclk = 1'b0;
                sh_d.tx   = {sh_q.tx[6:0], 1'b1};
                if (sh_q.bitn == 3'd7) begin
                    sh_d.active = 1'b0;
                    sh_d.done   = 1'b1;
                end else begin
                    sh_d.bitn = sh_q.bitn + 3'd1;
                end
            end
        end else begin
            sh_d.div = sh_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            sh_q.tx <= 8'hFF;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sclk    = sh_q.sclk;
    assign mosi    = sh_q.active ? sh_q.tx[7] : 1'b1;
    assign done    = sh_q.done;
    assign rx_byte = sh_q.rx;

endmodule

// File: rtl/sdrd_crc16.sv
module sdrd_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import sdrd_pkg::*;

    logic [15:0] crc_q, crc_d;

    always_comb begin
        crc_d = crc_q;
        if (clr)     crc_d = '0;
        else if (en) crc_d = crc16_step(crc_q, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

endmodule

// File: rtl/sdrd_read_engine.sv
module sdrd_read_engine #(
    parameter int BLOCK_BYTES = 512,
    parameter int HALF_DIV    = 2,
    parameter int NCR_MAX     = 8,
    parameter int PRE_IDLE    = 2,
    parameter int TOKW        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     blk_idx,
    input  logic            blk_addr_mode,
    input  logic [TOKW-1:0] tok_limit,
    output logic            busy,
    output logic            done,
    output logic [2:0]      err_code,
    output logic            rd_valid,
    output logic [7:0]      rd_data,
    output logic            spi_sclk,
    output logic            spi_cs_n,
    output logic            spi_mosi,
    input  logic            spi_miso
);
    import sdrd_pkg::*;

    localparam int BLK_SHIFT = $clog2(BLOCK_BYTES);
    localparam int CNT_W     = (TOKW > BLK_SHIFT + 1) ? TOKW : BLK_SHIFT + 1;

    typedef struct packed {
        sdrd_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             cs_n;
        logic             go;
        logic [7:0]       tx;
        logic [31:0]      arg;
        logic [7:0]       crc_hi;
        logic             done;
        sdrd_err_e        err;
        logic             valid;
        logic [7:0]       rdata;
    } eng_s;

    eng_s        q, d;
    logic        sh_done;
    logic [7:0]  sh_rx;
    logic [15:0] crc_now;
    logic        crc_clr, crc_en;

    sdrd_spi_byte #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (q.go),
        .tx_byte(q.tx),
        .miso   (spi_miso),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .done   (sh_done),
        .rx_byte(sh_rx)
    );

    sdrd_crc16 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (crc_clr),
        .en   (crc_en),
        .din  (sh_rx),
        .crc  (crc_now)
    );

    // Close the transaction: report, release chip select, clock one trailing byte.
    function automatic eng_s wrap_up(input eng_s s, input sdrd_err_e e);
        eng_s r;
        r      = s;
        r.st   = ST_TRAIL;
        r.cs_n = 1'b1;
        r.go   = 1'b1;
        r.tx   = IDLE_BYTE;
        r.done = 1'b1;
        r.err  = e;
        return r;
    endfunction

    always_comb begin
        d       = q;
        d.go    = 1'b0;
        d.done  = 1'b0;
        d.valid = 1'b0;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                d.st    = ST_PRE;
                d.cs_n  = 1'b0;
                d.go    = 1'b1;
                d.tx    = IDLE_BYTE;
                d.cnt   = '0;
                d.err   = ERR_NONE;
                d.arg   = blk_addr_mode ? blk_idx : (blk_idx << BLK_SHIFT);
                crc_clr = 1'b1;
            end
            ST_PRE: if (sh_done) begin
                d.go = 1'b1;
                if (q.cnt == CNT_W'(PRE_IDLE - 1)) begin
                    d.st  = ST_CMD;
                    d.cnt = '0;
                    d.tx  = CMD_RD_ONE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                    d.tx  = IDLE_BYTE;
                end
            end
            ST_CMD: if (sh_done) begin
                d.go = 1'b1;
                if (q.cnt < CNT_W'(4)) begin
                    d.tx  = q.arg[31:24];
                    d.arg = {q.arg[23:0], 8'h00};
                    d.cnt = q.cnt + CNT_W'(1);
                end else if (q.cnt == CNT_W'(4)) begin
                    d.tx  = IDLE_BYTE;
                    d.cnt = q.cnt + CNT_W'(1);
                end else begin
                    d.st  = ST_R1;
                    d.cnt = '0;
                    d.tx  = IDLE_BYTE;
                end
            end
            ST_R1: if (sh_done) begin
                if (!sh_rx[7]) begin
                    if (sh_rx == 8'h00) begin
                        d.st  = ST_TOKEN;
                        d.cnt = '0;
                        d.go  = 1'b1;
                        d.tx  = IDLE_BYTE;
                    end else begin
                        d = wrap_up(q, ERR_R1);
                    end
                end else if (q.cnt == CNT_W'(NCR_MAX - 1)) begin
                    d = wrap_up(q, ERR_NO_R1);
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                    d.go  = 1'b1;
                    d.tx  = IDLE_BYTE;
                end
            end
            ST_TOKEN: if (sh_done) begin
                if (sh_rx == START_TOKEN) begin
                    d.st  = ST_DATA;
                    d.cnt = '0;
                    d.go  = 1'b1;
                    d.tx  = IDLE_BYTE;
                end else if (sh_rx[7:5] == 3'b000) begin
                    d = wrap_up(q, ERR_TOKEN);
                end else if ((q.cnt + CNT_W'(1)) == CNT_W'(tok_limit)) begin
                    d = wrap_up(q, ERR_TIMEOUT);
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                    d.go  = 1'b1;
                    d.tx  = IDLE_BYTE;
                end
            end
            ST_DATA: if (sh_done) begin
                d.valid = 1'b1;
                d.rdata = sh_rx;
                crc_en  = 1'b1;
                d.go    = 1'b1;
                d.tx    = IDLE_BYTE;
                if (q.cnt == CNT_W'(BLOCK_BYTES - 1)) begin
                    d.st  = ST_CRC;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_CRC: if (sh_done) begin
                if (q.cnt == '0) begin
                    d.crc_hi = sh_rx;
                    d.cnt    = CNT_W'(1);
                    d.go     = 1'b1;
                    d.tx     = IDLE_BYTE;
                end else begin
                    d = wrap_up(q, ({q.crc_hi, sh_rx} == crc_now) ? ERR_NONE : ERR_CRC);
                end
            end
            ST_TRAIL: if (sh_done) d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
            q.tx   <= IDLE_BYTE;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign err_code = q.err;
    assign rd_valid = q.valid;
    assign rd_data  = q.rdata;
    assign spi_cs_n = q.cs_n;

endmodule

// File: rtl/sdrd_read_checker.sv
module sdrd_read_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] err_code,
    input logic       rd_valid,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic       spi_mosi
);
    // R13: pins parked while the engine does not own them
    p_idle_pins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !spi_sclk && spi_mosi));

    // R1: mode-0 timing, MOSI held while SCLK is high
    p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R1: chip select only drops inside a transaction
    p_cs_in_txn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> busy);

    // R9: data strobe is a single-cycle pulse inside a live transfer
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_valid_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && !spi_cs_n));

    // R11: done is one cycle, arrives with CS released and the trailing byte pending
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && busy));

    // R4: result codes stay within the defined set
    p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code <= 3'd5));

    // R12: a transaction begins only from a start request
    p_begin_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind sdrd_read_engine sdrd_read_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .err_code(err_code),
    .rd_valid(rd_valid),
    .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi)
);

// File: tb/sdrd_read_engine_bench.sv
module sdrd_read_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 32;
    localparam int TOK        = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] blk_idx;
    logic        blk_addr_mode;
    logic [15:0] tok_limit;
    logic        busy, done, rd_valid;
    logic [2:0]  err_code;
    logic [7:0]  rd_data;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdrd_read_engine #(
        .BLOCK_BYTES(NB), .HALF_DIV(2), .NCR_MAX(8), .PRE_IDLE(2), .TOKW(16)
    ) u_sdrd_read_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_idx(blk_idx),
        .blk_addr_mode(blk_addr_mode), .tok_limit(tok_limit), .busy(busy),
        .done(done), .err_code(err_code), .rd_valid(rd_valid), .rd_data(rd_data),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // ---------------- bookkeeping ----------------
    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- card model ----------------
    logic [7:0]  cfg_r1   = 8'h00;
    logic [7:0]  cfg_tok  = 8'hFE;
    logic [7:0]  cfg_seed = 8'h11;
    int          cfg_gap  = 5;
    bit          cfg_nor1 = 1'b0;
    bit          cfg_badcrc = 1'b0;

    int          bitc = 0, k = -1, cmd_pos = -1, pre_ff = 0, pre_ff_seen = 0;
    int          n_cmds = 0, hi_bits = 0;
    logic [7:0]  rxb = 8'hFF, txb = 8'hFF, trailer = 8'h00;
    logic [31:0] arg_seen = '0;
    logic        cs_prev = 1'b1, sclk_prev = 1'b0;

    assign spi_miso = spi_cs_n ? 1'b1 : txb[7];

    function automatic logic [7:0] data_of(input int idx);
        return 8'((idx * 37 + int'(cfg_seed)) & 255);
    endfunction

    function automatic logic [15:0] crc_ref();
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < NB; i++) begin
            c = c ^ {data_of(i), 8'h00};
            for (int b = 0; b < 8; b++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [7:0] slot(input int kk);
        int          dd;
        logic [15:0] c;
        if (kk == 0) return 8'hFF;
        if (kk == 1) return cfg_nor1 ? 8'hFF : cfg_r1;
        if (cfg_nor1 || cfg_r1 != 8'h00) return 8'hFF;
        if (kk < 2 + cfg_gap) return 8'hFF;
        if (kk == 2 + cfg_gap) return cfg_tok;
        if (cfg_tok != 8'hFE) return 8'hFF;
        dd = kk - 3 - cfg_gap;
        c  = crc_ref();
        if (dd < NB) return data_of(dd);
        if (dd == NB) return c[15:8] ^ (cfg_badcrc ? 8'h01 : 8'h00);
        if (dd == NB + 1) return c[7:0];
        return 8'hFF;
    endfunction

    task model_byte();
        if (cmd_pos >= 0) begin
            cmd_pos++;
            if (cmd_pos <= 4) arg_seen = {arg_seen[23:0], rxb};
            else begin
                trailer = rxb;
                cmd_pos = -1;
                k = 0;
            end
        end else if (k < 0) begin
            if (rxb == 8'h51) begin
                cmd_pos = 0;
                n_cmds++;
                pre_ff_seen = pre_ff;
            end else if (rxb == 8'hFF) pre_ff++;
        end
        if (k >= 0) begin
            txb = slot(k);
            k++;
        end else txb = 8'hFF;
    endtask

    always @(spi_sclk or spi_cs_n) begin
        if (spi_cs_n !== cs_prev) begin
            cs_prev = spi_cs_n;
            if (!spi_cs_n) begin
                bitc = 0; txb = 8'hFF; k = -1; cmd_pos = -1; pre_ff = 0;
            end
        end else if (spi_sclk !== sclk_prev) begin
            sclk_prev = spi_sclk;
            if (spi_sclk) begin
                if (!spi_cs_n) rxb = {rxb[6:0], spi_mosi};
            end else if (spi_cs_n) begin
                hi_bits++;
            end else begin
                txb = {txb[6:0], 1'b1};
                bitc++;
                if (bitc == 8) begin
                    bitc = 0;
                    model_byte();
                end
            end
        end
    end

    // ---------------- host-side monitor ----------------
    int         rd_cnt = 0, bad_data = 0, dbl_valid = 0, done_cnt = 0;
    logic [2:0] err_seen = '0;
    logic       prev_valid = 1'b0;

    always @(negedge clk) begin
        if (rd_valid) begin
            if (rd_data !== data_of(rd_cnt)) bad_data++;
            rd_cnt++;
        end
        if (rd_valid && prev_valid) dbl_valid++;
        prev_valid = rd_valid;
        if (done) begin
            done_cnt++;
            err_seen = err_code;
        end
    end

    // ---------------- scenario driver ----------------
    task automatic run_read(input logic [31:0] idx, input logic mode,
                            input logic [31:0] exp_arg, input string arg_req,
                            input int exp_err, input string err_req,
                            input int exp_bytes, input bit mid_start);
        int d0, c0;
        @(negedge clk);
        d0 = done_cnt; c0 = n_cmds;
        rd_cnt = 0; bad_data = 0; dbl_valid = 0; hi_bits = 0;
        blk_idx = idx; blk_addr_mode = mode; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (300) @(negedge clk);
            blk_idx = ~idx; blk_addr_mode = ~mode; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 40000 && done_cnt == d0; i++) @(negedge clk);
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        check(done_cnt == d0 + 1, "R11", "done pulses", done_cnt - d0, 1);
        check(int'(err_seen) == exp_err, err_req, "err_code", err_seen, exp_err);
        check(rd_cnt == exp_bytes, "R9", "bytes delivered", rd_cnt, exp_bytes);
        check(bad_data == 0 && dbl_valid == 0, "R9", "data order/strobe errors",
              bad_data + dbl_valid, 0);
        check(n_cmds == c0 + 1, "R12", "commands sent", n_cmds - c0, 1);
        check(arg_seen == exp_arg, arg_req, "argument", arg_seen, exp_arg);
        check(pre_ff_seen == 2 && trailer == 8'hFF, "R1", "lead idle bytes",
              pre_ff_seen, 2);
        check(hi_bits == 8, "R11", "trailing clocks with CS high", hi_bits, 8);
        check(!busy && spi_cs_n && !spi_sclk && spi_mosi, "R13", "idle pins",
              {busy, spi_cs_n, spi_sclk, spi_mosi}, 4'b0101);
    endtask

    task automatic set_defaults();
        cfg_r1 = 8'h00; cfg_tok = 8'hFE; cfg_gap = 5;
        cfg_nor1 = 1'b0; cfg_badcrc = 1'b0;
    endtask

    task automatic t_reset();
        check(spi_cs_n && !spi_sclk && spi_mosi, "R13", "pins in reset",
              {spi_cs_n, spi_sclk, spi_mosi}, 3'b101);
        check(!busy && !done && !rd_valid, "R13", "status in reset",
              {busy, done, rd_valid}, 0);
    endtask

    task automatic t_byte_addr();
        set_defaults(); cfg_seed = 8'h11;
        run_read(32'd3, 1'b0, 32'h0000_0060, "R2", 0, "R10", NB, 1'b0);
    endtask

    task automatic t_block_addr();
        set_defaults(); cfg_seed = 8'h5A; cfg_gap = 0;
        run_read(32'h0123_4567, 1'b1, 32'h0123_4567, "R3", 0, "R6", NB, 1'b0);
    endtask

    task automatic t_addr_wrap();
        set_defaults(); cfg_seed = 8'h02;
        run_read(32'h0800_0001, 1'b0, 32'h0000_0020, "R2", 0, "R10", NB, 1'b0);
    endtask

    task automatic t_r1_error();
        set_defaults(); cfg_r1 = 8'h20;
        run_read(32'd7, 1'b0, 32'h0000_00E0, "R2", 1, "R5", 0, 1'b0);
        check(k == 3, "R5", "reply slots clocked under CS", k, 3);
    endtask

    task automatic t_no_r1();
        set_defaults(); cfg_nor1 = 1'b1;
        run_read(32'd9, 1'b1, 32'd9, "R3", 5, "R4", 0, 1'b0);
    endtask

    task automatic t_gap_edge();
        set_defaults(); cfg_seed = 8'hC3; cfg_gap = TOK - 1;
        run_read(32'd1, 1'b1, 32'd1, "R3", 0, "R6", NB, 1'b0);
    endtask

    task automatic t_timeout();
        set_defaults(); cfg_gap = TOK;
        run_read(32'd2, 1'b1, 32'd2, "R3", 3, "R7", 0, 1'b0);
    endtask

    task automatic t_err_token();
        set_defaults(); cfg_tok = 8'h08;
        run_read(32'd4, 1'b1, 32'd4, "R3", 2, "R8", 0, 1'b0);
    endtask

    task automatic t_bad_crc();
        set_defaults(); cfg_seed = 8'h77; cfg_badcrc = 1'b1;
        run_read(32'd5, 1'b0, 32'h0000_00A0, "R2", 4, "R10", NB, 1'b0);
    endtask

    task automatic t_start_busy();
        set_defaults(); cfg_seed = 8'h3C;
        run_read(32'd6, 1'b1, 32'd6, "R12", 0, "R10", NB, 1'b1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        rst_n = 1'b0; start = 1'b0; blk_idx = '0; blk_addr_mode = 1'b0;
        tok_limit = 16'(TOK);
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_byte_addr();
        t_block_addr();
        t_addr_wrap();
        t_r1_error();
        t_no_r1();
        t_gap_edge();
        t_timeout();
        t_err_token();
        t_bad_crc();
        t_start_busy();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule